// File: doc/BRIEF.md
# Byte-Code Register Sequencer

This block runs a short program of variable-length byte commands from a small local memory. It was built for power and clock switching work, where a fixed series of register writes has to go out with controlled gaps between them. The commands can issue register writes on a write-request port, drive or release a bank of 32 output flags, stall until one of 32 input flags reaches a given level, and wait for a delay counted in microseconds. The host loads the program through a word write port while the engine is idle. It then pulses `go` and polls `busy` until it falls.

The engine holds two registers, one for the address and one for the data. Each can be loaded in full with four operand bytes, or only in its low half with two operand bytes. A data command only updates the data register. An address command updates the address register and, in the cycle after its last operand byte, issues one write of the current data register to the new address. A delay command packs a 2-bit mantissa and a 4-bit base-4 exponent into its opcode. A parameterised clock divider produces the microsecond tick that the delay counts.

Top module: `bseq_engine`

## Requirements
- R1: After reset `busy` is 0, `wr_valid` is 0, and `flag_out` and `flag_en` are all 0.
- R2: A word written on the program port while idle is stored. Program byte k is bits [8*(k%4)+7 : 8*(k%4)] of word k/4. A program-port write made while `busy` is 1 is ignored.
- R3: A `go` pulse seen while idle makes `busy` 1 in the next cycle, and execution starts at byte 0. A `go` pulse seen while busy has no effect.
- R4: Opcode 0x7F ends execution: `busy` falls in the cycle after that byte is fetched. Running past the last byte of the memory also ends execution, one cycle after the last byte is consumed.
- R5: Opcode 0x40 with two operand bytes (low byte first) replaces address bits 15:0 and keeps bits 31:16. One cycle after the last operand, `wr_valid` pulses for one cycle with the full address and the current data register.
- R6: Opcode 0xE0 with four operand bytes (least significant first) replaces the whole address and issues a write in the same way as R5.
- R7: Opcode 0x42 (two bytes) replaces data bits 15:0, and opcode 0xE2 (four bytes) replaces all 32 data bits. Neither one issues a write.
- R8: Opcodes 0x80 to 0xDF act on flag n = bits 4:0, and the action is taken from bits 6:5. Action 0 sets `flag_en[n]`=0 and `flag_out[n]`=0. Action 1 sets enable 1 and value 0. Action 2 sets enable 1 and value 1. The flags change only while running.
- R9: Opcode 0x5F reads two bytes: a flag index (bits 4:0) and a level (bit 0). Execution stalls until `flag_in[index]` equals that level at a clock edge, and resumes fetching in the next cycle.
- R10: An opcode with bits 7:6 = 00 is a delay of mantissa (bits 1:0) × 4^shift (bits 5:2) microsecond ticks, and it occupies exactly units × TICK_DIV cycles after its fetch cycle. A zero mantissa makes it a one-cycle no-op.
- R11: Every opcode fetch and every operand byte takes exactly one cycle.
- R12: Any other opcode value (for example 0x41, 0x60, 0xE1, 0xF0) is skipped as a one-byte no-op.
- R13: A multi-byte command cut off by the end of the memory ends execution and changes no register and issues no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Program word write strobe |
| prog_addr | input | $clog2(PROG_WORDS) | Program word index |
| prog_wdata | input | 32 | Program word data |
| go | input | 1 | Start pulse |
| flag_in | input | 32 | Input flags tested by the wait command |
| busy | output | 1 | High while a program runs |
| wr_valid | output | 1 | One-cycle register write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| flag_out | output | 32 | Output flag levels |
| flag_en | output | 32 | Output flag drive enables |

## Verification
If the byte pointer or the operand counter is wrong, the next write lands at a shifted address, or `busy` falls early or late. Either shows up within a few cycles of the faulty byte. A stale half of the address or data register shows on the first short-form write that follows it. A delay count that is off by one tick moves the next flag or write by TICK_DIV cycles. The wait command must hold `busy` high for as long as the input flag is at the wrong level. The bench compares every output on every cycle against a behavioural model, so each of these faults is reported in the cycle where it first appears.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_OPER,
      ST_WAIT,
      ST_DELAY
   } bseq_state_e;

   typedef enum logic [3:0] {
      K_END,
      K_DELAY,
      K_FLAG,
      K_ADDR_S,
      K_ADDR_L,
      K_DATA_S,
      K_DATA_L,
      K_WAIT,
      K_SKIP
   } bseq_kind_e;

   localparam logic [7:0] OPC_STOP      = 8'h7F;
   localparam logic [7:0] OPC_ADDR_HALF = 8'h40;
   localparam logic [7:0] OPC_ADDR_FULL = 8'hE0;
   localparam logic [7:0] OPC_DATA_HALF = 8'h42;
   localparam logic [7:0] OPC_DATA_FULL = 8'hE2;
   localparam logic [7:0] OPC_WAITFLAG  = 8'h5F;

   function automatic bseq_kind_e classify(input logic [7:0] b);
      bseq_kind_e k;
      if (b == OPC_STOP)                        k = K_END;
      else if (b == OPC_ADDR_HALF)              k = K_ADDR_S;
      else if (b == OPC_ADDR_FULL)              k = K_ADDR_L;
      else if (b == OPC_DATA_HALF)              k = K_DATA_S;
      else if (b == OPC_DATA_FULL)              k = K_DATA_L;
      else if (b == OPC_WAITFLAG)               k = K_WAIT;
      else if (b[7:6] == 2'b00)                 k = K_DELAY;
      else if (b[7] && (b[6:5] != 2'b11))       k = K_FLAG;
      else                                      k = K_SKIP;
      return k;
   endfunction

   // microsecond units encoded by a delay opcode: mantissa << (2*shift)
   function automatic logic [31:0] delay_units(input logic [5:0] b);
      return 32'(b[1:0]) << {b[5:2], 1'b0};
   endfunction

endpackage

// File: rtl/bseq_prog_mem.sv
module bseq_prog_mem #(
   parameter int WORDS = 64,
   localparam int AW   = $clog2(WORDS),
   localparam int BW   = AW + 2
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [31:0]   wdata,
   input  logic [BW-1:0] raddr,
   output logic [7:0]    rbyte
);

   logic [31:0] mem [WORDS];
   logic [31:0] word;
   logic [7:0]  lanes [4];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign word = mem[raddr[BW-1:2]];

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign lanes[g] = word[8*g +: 8];
   end

   assign rbyte = lanes[raddr[1:0]];

endmodule

// File: rtl/bseq_tick_gen.sv
module bseq_tick_gen #(
   parameter int DIV = 4,
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (clr)                    cnt <= '0;
      else if (en) begin
         if (cnt == CW'(DIV - 1))      cnt <= '0;
         else                          cnt <= cnt + 1'b1;
      end
   end

   assign tick = en && (cnt == CW'(DIV - 1));

   AST_TICK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < DIV); // R10

endmodule

// File: rtl/bseq_delay_ctr.sv
module bseq_delay_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             last
);

   logic [CNT_W-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rem <= '0;
      else if (load)                 rem <= load_val;
      else if (tick && rem != '0)    rem <= rem - 1'b1;
   end

   assign last = (rem == CNT_W'(1));

   AST_DELAY_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (rem != '0)); // R10

endmodule

// File: rtl/bseq_flag_bank.sv
module bseq_flag_bank #(
   parameter int IW = 5,
   localparam int NF = 1 << IW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic [IW-1:0] idx,
   input  logic [1:0]    act,
   output logic [NF-1:0] lvl,
   output logic [NF-1:0] drv
);

   for (genvar f = 0; f < NF; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl[f] <= 1'b0;
            drv[f] <= 1'b0;
         end else if (upd && idx == IW'(f)) begin
            lvl[f] <= (act == 2'd2);
            drv[f] <= (act != 2'd0);
         end
      end
   end

   AST_FLAG_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> (act != 2'b11)); // R8

endmodule

// File: rtl/bseq_engine.sv
module bseq_engine
   import bseq_pkg::*;
#(
   parameter int PROG_WORDS = 64,
   parameter int TICK_DIV   = 4,
   localparam int MEM_AW    = $clog2(PROG_WORDS),
   localparam int BYTE_AW   = MEM_AW + 2,
   localparam int PTR_W     = BYTE_AW + 1,
   localparam int NUM_BYTES = PROG_WORDS * 4,
   localparam int FLAG_IW   = 5,
   localparam int NUM_FLAGS = 1 << FLAG_IW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prog_we,
   input  logic [MEM_AW-1:0]    prog_addr,
   input  logic [31:0]          prog_wdata,
   input  logic                 go,
   input  logic [NUM_FLAGS-1:0] flag_in,
   output logic                 busy,
   output logic                 wr_valid,
   output logic [31:0]          wr_addr,
   output logic [31:0]          wr_data,
   output logic [NUM_FLAGS-1:0] flag_out,
   output logic [NUM_FLAGS-1:0] flag_en
);

   if (PROG_WORDS < 2 || (PROG_WORDS & (PROG_WORDS - 1)) != 0) begin : g_bad_depth
      $error("PROG_WORDS must be a power of two of at least 2");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end

   bseq_state_e        state;
   logic [PTR_W-1:0]   ptr;
   bseq_kind_e         op_q;
   logic [1:0]         cnt_q;
   logic [23:0]        asm_q;
   logic [31:0]        addr_q, data_q;
   logic [FLAG_IW-1:0] widx_q;
   logic               wlvl_q;
   logic               wr_valid_q;
   logic [31:0]        wr_addr_q, wr_data_q;

   logic [7:0]         cur;
   bseq_kind_e         kind;
   logic               at_end;
   logic               fetching;
   logic               last_opnd;
   logic [31:0]        units;
   logic               tick, dly_last;

   bseq_prog_mem #(.WORDS(PROG_WORDS)) u_mem (
      .clk   (clk),
      .we    (prog_we && state == ST_IDLE),
      .waddr (prog_addr),
      .wdata (prog_wdata),
      .raddr (ptr[BYTE_AW-1:0]),
      .rbyte (cur)
   );

   assign kind     = classify(cur);
   assign at_end   = (ptr == PTR_W'(NUM_BYTES));
   assign fetching = (state == ST_FETCH) && !at_end;
   assign units    = delay_units(cur[5:0]);
   assign last_opnd = (op_q == K_ADDR_L || op_q == K_DATA_L) ? (cnt_q == 2'd3)
                                                             : (cnt_q == 2'd1);

   bseq_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != ST_DELAY),
      .en    (state == ST_DELAY),
      .tick  (tick)
   );

   bseq_delay_ctr #(.CNT_W(32)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fetching && kind == K_DELAY),
      .load_val (units),
      .tick     (tick),
      .last     (dly_last)
   );

   bseq_flag_bank #(.IW(FLAG_IW)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (fetching && kind == K_FLAG),
      .idx   (cur[FLAG_IW-1:0]),
      .act   (cur[6:5]),
      .lvl   (flag_out),
      .drv   (flag_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ptr        <= '0;
         op_q       <= K_SKIP;
         cnt_q      <= '0;
         asm_q      <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         widx_q     <= '0;
         wlvl_q     <= 1'b0;
         wr_valid_q <= 1'b0;
         wr_addr_q  <= '0;
         wr_data_q  <= '0;
      end else begin
         wr_valid_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  state <= ST_FETCH;
                  ptr   <= '0;
               end
            end
            ST_FETCH: begin
               if (at_end) begin
                  state <= ST_IDLE;
               end else begin
                  ptr <= ptr + 1'b1;
                  unique case (kind)
                     K_END:   state <= ST_IDLE;
                     K_DELAY: if (units != '0) state <= ST_DELAY;
                     K_ADDR_S, K_ADDR_L, K_DATA_S, K_DATA_L, K_WAIT: begin
                        op_q  <= kind;
                        cnt_q <= '0;
                        state <= ST_OPER;
                     end
                     default: ;
                  endcase
               end
            end
            ST_OPER: begin
               if (at_end) begin
                  state <= ST_IDLE;
               end else begin
                  ptr <= ptr + 1'b1;
                  if (!last_opnd) begin
                     cnt_q <= cnt_q + 1'b1;
                     unique case (cnt_q)
                        2'd0:    asm_q[7:0]   <= cur;
                        2'd1:    asm_q[15:8]  <= cur;
                        default: asm_q[23:16] <= cur;
                     endcase
                  end else begin
                     state <= ST_FETCH;
                     unique case (op_q)
                        K_ADDR_S: begin
                           addr_q     <= {addr_q[31:16], cur, asm_q[7:0]};
                           wr_addr_q  <= {addr_q[31:16], cur, asm_q[7:0]};
                           wr_data_q  <= data_q;
                           wr_valid_q <= 1'b1;
                        end
                        K_ADDR_L: begin
                           addr_q     <= {cur, asm_q};
                           wr_addr_q  <= {cur, asm_q};
                           wr_data_q  <= data_q;
                           wr_valid_q <= 1'b1;
                        end
                        K_DATA_S: data_q <= {data_q[31:16], cur, asm_q[7:0]};
                        K_DATA_L: data_q <= {cur, asm_q};
                        default: begin
                           widx_q <= asm_q[FLAG_IW-1:0];
                           wlvl_q <= cur[0];
                           state  <= ST_WAIT;
                        end
                     endcase
                  end
               end
            end
            ST_WAIT: begin
               if (flag_in[widx_q] == wlvl_q) state <= ST_FETCH;
            end
            default: begin
               if (tick && dly_last) state <= ST_FETCH;
            end
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign wr_valid = wr_valid_q;
   assign wr_addr  = wr_addr_q;
   assign wr_data  = wr_data_q;

   AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go) |=> busy); // R3
   AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> busy); // R5
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid); // R11
   AST_FLAGS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(flag_out) && $stable(flag_en))); // R8
   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr) <= NUM_BYTES); // R4

endmodule

// File: tb/bseq_engine_tb_top.sv
`timescale 1ns/1ps
module bseq_engine_tb_top;

   localparam int PW  = 64;
   localparam int DIV = 4;
   localparam int NB  = PW * 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prog_we = 1'b0;
   logic [5:0]        prog_addr = '0;
   logic [31:0]       prog_wdata = '0;
   logic              go = 1'b0;
   logic [31:0]       flag_in = '0;
   logic              busy, wr_valid;
   logic [31:0]       wr_addr, wr_data, flag_out, flag_en;

   always #4 clk = ~clk;   // 125 MHz

   bseq_engine #(.PROG_WORDS(PW), .TICK_DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_wdata(prog_wdata), .go(go), .flag_in(flag_in), .busy(busy),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .flag_out(flag_out), .flag_en(flag_en));

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   logic [7:0] pbuf [NB];

   // ---------------- behavioural reference model ----------------
   int unsigned m_mem [PW];
   int          m_state = 0;        // 0 idle,1 fetch,2 operand,3 wait,4 delay
   int          m_pc = 0, m_need = 0, m_got = 0, m_cmd = 0;
   int          m_ops [$];
   int unsigned m_addr = 0, m_data = 0, m_wra = 0, m_wrd = 0;
   int          m_widx = 0, m_wlvl = 0;
   longint      m_rem = 0;
   bit          m_wrv = 0;
   bit [31:0]   m_fo = '0, m_fe = '0;

   function automatic int mbyte(int pc);
      return int'((m_mem[pc / 4] >> (8 * (pc % 4))) & 32'hFF);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_addr = 0; m_data = 0; m_wrv = 0; m_fo = '0; m_fe = '0;
      end else begin
         m_wrv = 0;
         if (m_state == 0) begin
            if (prog_we) m_mem[prog_addr] = prog_wdata;
            if (go) begin m_state = 1; m_pc = 0; end
         end else if (m_state == 1) begin
            if (m_pc >= NB) m_state = 0;
            else begin
               int b;
               b = mbyte(m_pc);
               m_pc++;
               if (b == 127) m_state = 0;
               else if (b == 64 || b == 66 || b == 95 || b == 224 || b == 226) begin
                  m_cmd = b; m_need = (b >= 224) ? 4 : 2; m_got = 0;
                  m_ops.delete(); m_state = 2;
               end else if (b < 64) begin
                  longint u;
                  u = longint'(b % 4) * (longint'(1) << (2 * (b / 4)));
                  if (u != 0) begin m_rem = u * DIV; m_state = 4; end
               end else if (b >= 128 && b < 224) begin
                  int n, a;
                  n = b % 32; a = (b / 32) % 4;
                  m_fe[n] = (a != 0);
                  m_fo[n] = (a == 2);
               end
            end
         end else if (m_state == 2) begin
            if (m_pc >= NB) m_state = 0;
            else begin
               m_ops.push_back(mbyte(m_pc));
               m_pc++;
               m_got++;
               if (m_got == m_need) begin
                  int unsigned v;
                  v = 0;
                  foreach (m_ops[i]) v = v | (int'(m_ops[i]) << (8 * i));
                  m_state = 1;
                  if (m_cmd == 95) begin
                     m_widx = m_ops[0] % 32; m_wlvl = m_ops[1] % 2; m_state = 3;
                  end else if (m_cmd == 66) m_data = (m_data & 32'hFFFF0000) | v;
                  else if (m_cmd == 226) m_data = v;
                  else begin
                     m_addr = (m_cmd == 224) ? v : ((m_addr & 32'hFFFF0000) | v);
                     m_wrv = 1; m_wra = m_addr; m_wrd = m_data;
                  end
               end
            end
         end else if (m_state == 3) begin
            if (int'(flag_in[m_widx]) == m_wlvl) m_state = 1;
         end else begin
            m_rem--;
            if (m_rem == 0) m_state = 1;
         end
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("busy", 32'(busy), 32'(m_state != 0));
         chk("wr_valid", 32'(wr_valid), 32'(m_wrv));
         if (m_wrv) begin
            chk("wr_addr", wr_addr, m_wra);
            chk("wr_data", wr_data, m_wrd);
         end
         chk("flag_out", flag_out, m_fo);
         chk("flag_en", flag_en, m_fe);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic clear_buf(logic [7:0] fill);
      for (int i = 0; i < NB; i++) pbuf[i] = fill;
   endtask

   task automatic load_buf();
      for (int w = 0; w < PW; w++) begin
         @(negedge clk);
         prog_we = 1'b1; prog_addr = 6'(w);
         prog_wdata = {pbuf[4*w+3], pbuf[4*w+2], pbuf[4*w+1], pbuf[4*w]};
      end
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   task automatic run_prog(int limit);
      int c;
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
      c = 0;
      while (busy && c < limit) begin @(negedge clk); c++; end
      if (busy) begin
         n_bad++;
         $display("FAIL %s run did not end act=busy exp=idle", cur_req);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("reset busy", 32'(busy), 32'd0);
      chk("reset flags", flag_out | flag_en, 32'd0);

      // writes: long data, long addr, short data, short addr
      cur_req = "R2 R5 R6 R7 R11";
      clear_buf(8'h7F);
      {pbuf[0],pbuf[1],pbuf[2],pbuf[3],pbuf[4]}   = {8'hE2,8'h78,8'h56,8'h34,8'h12};
      {pbuf[5],pbuf[6],pbuf[7],pbuf[8],pbuf[9]}   = {8'hE0,8'h00,8'h10,8'hA0,8'h00};
      {pbuf[10],pbuf[11],pbuf[12]}                = {8'h42,8'hCD,8'hAB};
      {pbuf[13],pbuf[14],pbuf[15]}                = {8'h40,8'h04,8'h20};
      {pbuf[16],pbuf[17],pbuf[18]}                = {8'h40,8'h08,8'h20};
      load_buf();
      cur_req = "R3 R4 R5 R6 R7 R11";
      run_prog(200);

      // flag actions
      cur_req = "R8";
      clear_buf(8'h7F);
      {pbuf[0],pbuf[1],pbuf[2],pbuf[3],pbuf[4],pbuf[5]} =
         {8'hC5, 8'hA3, 8'hDF, 8'hC1, 8'h81, 8'h9F};
      load_buf();
      run_prog(200);

      // wait on input flags
      cur_req = "R9";
      clear_buf(8'h7F);
      {pbuf[0],pbuf[1],pbuf[2]} = {8'h5F, 8'h02, 8'h00};
      {pbuf[3],pbuf[4],pbuf[5]} = {8'h5F, 8'h27, 8'h01};
      pbuf[6] = 8'hC9;
      load_buf();
      fork
         run_prog(500);
         begin repeat (40) @(negedge clk); flag_in[7] = 1'b1; end
      join
      flag_in = '0;

      // delays
      cur_req = "R10";
      clear_buf(8'h7F);
      {pbuf[0],pbuf[1],pbuf[2],pbuf[3],pbuf[4],pbuf[5],pbuf[6]} =
         {8'h05, 8'hC0, 8'h02, 8'h00, 8'hA0, 8'h0A, 8'hC2};
      load_buf();
      run_prog(1000);

      // unknown opcodes
      cur_req = "R12";
      clear_buf(8'h7F);
      {pbuf[0],pbuf[1],pbuf[2],pbuf[3],pbuf[4]} = {8'h41, 8'h60, 8'hE1, 8'hF0, 8'hC4};
      load_buf();
      run_prog(200);

      // run off the end, truncated command at the tail
      cur_req = "R4 R13";
      clear_buf(8'h00);
      pbuf[5] = 8'hC6;
      {pbuf[NB-3],pbuf[NB-2],pbuf[NB-1]} = {8'hE0, 8'h11, 8'h22};
      load_buf();
      run_prog(1000);

      // load and go while busy are ignored
      cur_req = "R2 R3";
      clear_buf(8'h7F);
      {pbuf[0],pbuf[1]} = {8'h0A, 8'hC3};
      load_buf();
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
      repeat (5) @(negedge clk);
      prog_we = 1'b1; prog_addr = 6'd0; prog_wdata = 32'h7F7F_C1C8;
      @(negedge clk); prog_we = 1'b0; go = 1'b1;
      @(negedge clk); go = 1'b0;
      while (busy) @(negedge clk);
      chk("flag3 after busy-time load", 32'(flag_out[3]), 32'd1);
      run_prog(500);
      chk("flag1 untouched", 32'(flag_en[1]), 32'd0);

      finish_up();
   end

endmodule